// File: doc/BRIEF.md
# Quad Pulse-Density Modulator

This block turns four 8-bit level values into four 1-bit pulse-density streams. Each channel owns an 8-bit integrator. On every tick the channel's stored level is added to its integrator modulo 256, and the carry out of that sum becomes the channel's output bit for that slot. A level L therefore produces exactly L high slots in any run of 256 ticks, and those high slots are spread out as evenly as the arithmetic allows instead of being grouped into one pulse. That pushes the switching energy to the highest possible rate, which makes an external low-pass filter easy to build.

The four output bits are packed into the low nibble of an 8-bit port byte, with the upper nibble held at zero. Levels come in through a valid/ready load interface that carries all four levels in one 32-bit word. Ready is tied high, so the block never applies back-pressure: every cycle with valid high is a completed transfer. A loaded level is first used at the next tick. The tick is a one-cycle enable strobe from the same clock domain. Without a tick, nothing in the block changes.

Top module: `pdm_quad`

## Requirements
- R1: While rst is high, every integrator, every stored level and port_out are cleared to zero.
- R2: On a cycle with tick high, channel i computes s = acc_i + level_i. Its integrator becomes s mod 256 and its output bit becomes 1 exactly when s >= 256. The new values are visible after that same clock edge.
- R3: Across any 256 consecutive ticks with a fixed level L, the channel's output bit is high in exactly L of them.
- R4: A level of 128 makes the output bit toggle on every tick.
- R5: A level of 1 gives one high slot per 256 ticks. A level of 255 gives one low slot per 256 ticks.
- R6: A level of 0 keeps the output bit low and leaves the integrator unchanged.
- R7: Channel i drives bit i of port_out (bit 0 for channel 0 up to bit 3 for channel 3). Bits 7..4 are always zero.
- R8: On a cycle without tick, port_out and the integrators keep their values.
- R9: lvl_ready is always high. A cycle with lvl_valid high stores lvl_data, with channel i taken from bits [8i+7:8i]. A tick in that same cycle still uses the previously stored levels, and the new levels apply from the next tick on.
- R10: For any level of 128 or less, no two consecutive ticks both produce a high bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle slot strobe |
| lvl_valid | input | 1 | Level word offered |
| lvl_ready | output | 1 | Always high; the block never stalls |
| lvl_data | input | 32 | Four 8-bit levels, channel i in bits [8i+7:8i] |
| port_out | output | 8 | Packed output bits; channel i on bit i, bits 7..4 zero |

## Verification
Every one of the 256 level values is run for a full 256-tick window, with the four channels given levels 64 apart so that a swapped bit position produces different streams. Each slot is compared against an arithmetic integrator model. At the end of each window the count of high slots is compared with the level. Along the way the sweep checks the special levels: 0 must stay silent, 128 must alternate, 1 and 255 must give a single odd slot, and any level up to 128 must never give two highs in a row. Idle cycles between ticks show that the output holds. A load placed on the same cycle as a tick tells apart designs that apply new levels immediately from ones that wait for the next tick. A mid-run reset shows that integrators and levels are really cleared.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  parameter int PDM_CHANNELS = 4;
  parameter int PDM_LEVEL_W  = 8;
  parameter int PDM_PORT_W   = 8;
endpackage

// File: rtl/pdm_level_bank.sv
module pdm_level_bank #(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_valid,
  input  logic [NCH*W-1:0] ld_data,
  output logic [NCH*W-1:0] lvl_q
);
  always_ff @(posedge clk) begin
    if (rst)           lvl_q <= '0;
    else if (ld_valid) lvl_q <= ld_data;
  end

  // R9
  lvl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid |=> $stable(lvl_q));
  // R9
  lvl_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (lvl_q == $past(ld_data)));
endmodule

// File: rtl/pdm_channel.sv
module pdm_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] level,
  output logic         bit_q
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, level};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      bit_q <= 1'b0;
    end else if (tick) begin
      acc_q <= sum[W-1:0];
      bit_q <= sum[W];
    end
  end

  // R2: a high bit must coincide with the integrator wrapping
  carry_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (bit_q == (acc_q < $past(acc_q))));
  // R6
  zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && level == '0) |=> (!bit_q && $stable(acc_q)));
  // R8
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(acc_q) && $stable(bit_q)));
  // R10
  no_double_high_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && bit_q && level <= (1 << (W-1))) |=> !bit_q);
endmodule

// File: rtl/pdm_port_pack.sv
module pdm_port_pack #(
  parameter int NCH    = 4,
  parameter int PORT_W = 8
) (
  input  logic [NCH-1:0]    bits,
  output logic [PORT_W-1:0] port
);
  localparam int PAD_W = PORT_W - NCH;

  generate
    if (PAD_W > 0) begin : g_pad
      assign port = {{PAD_W{1'b0}}, bits};
    end else begin : g_nopad
      assign port = bits[PORT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pdm_quad.sv
module pdm_quad
  import pdm_pkg::*;
#(
  parameter int NCH    = PDM_CHANNELS,
  parameter int W      = PDM_LEVEL_W,
  parameter int PORT_W = PDM_PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              lvl_valid,
  output logic              lvl_ready,
  input  logic [NCH*W-1:0]  lvl_data,
  output logic [PORT_W-1:0] port_out
);
  logic [NCH*W-1:0] lvl_q;
  logic [NCH-1:0]   bits;

  assign lvl_ready = 1'b1;

  pdm_level_bank #(.NCH(NCH), .W(W)) u_bank (
    .clk(clk), .rst(rst), .ld_valid(lvl_valid), .ld_data(lvl_data), .lvl_q(lvl_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pdm_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick),
      .level(lvl_q[i*W +: W]), .bit_q(bits[i])
    );
  end

  pdm_port_pack #(.NCH(NCH), .PORT_W(PORT_W)) u_pack (
    .bits(bits), .port(port_out)
  );

  // R8
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(port_out));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (port_out == '0));
endmodule

// File: tb/sim_pdm_quad.sv
`timescale 1ns/1ps
module sim_pdm_quad;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        lvl_valid = 1'b0;
  logic        lvl_ready;
  logic [31:0] lvl_data = '0;
  logic [7:0]  port_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_acc [4];
  logic [7:0] m_lvl [4];
  logic [7:0] m_out;

  always #4 clk = ~clk;

  pdm_quad u0 (
    .clk(clk), .rst(rst), .tick(tick), .lvl_valid(lvl_valid),
    .lvl_ready(lvl_ready), .lvl_data(lvl_data), .port_out(port_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_acc[i] = 0; m_lvl[i] = 0; end
    m_out = 0;
  endtask

  task automatic model_tick();
    for (int i = 0; i < 4; i++) begin
      logic [8:0] s;
      s = {1'b0, m_acc[i]} + {1'b0, m_lvl[i]};
      m_acc[i] = s[7:0];
      m_out[i] = s[8];
    end
    m_out[7:4] = 4'h0;
  endtask

  task automatic load(input logic [7:0] l0, l1, l2, l3);
    @(negedge clk);
    lvl_valid = 1'b1;
    lvl_data  = {l3, l2, l1, l0};
    @(negedge clk);
    lvl_valid = 1'b0;
    m_lvl[0] = l0; m_lvl[1] = l1; m_lvl[2] = l2; m_lvl[3] = l3;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    model_tick();
    @(negedge clk);
    tick = 1'b0;
    chk(port_out == m_out, "R2", port_out, m_out);
  endtask

  int  hi_cnt [4];
  logic prev_bit [4];

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk(port_out == 8'h00, "R1", port_out, 0);
    chk(lvl_ready == 1'b1, "R9", lvl_ready, 1);
    rst = 1'b0;

    // Full sweep: every level value on some channel, channels 64 apart
    for (int g = 0; g < 64; g++) begin
      load(8'(g), 8'(g + 64), 8'(g + 128), 8'(g + 192));
      for (int i = 0; i < 4; i++) begin hi_cnt[i] = 0; prev_bit[i] = 1'b0; end
      for (int t = 0; t < 256; t++) begin
        tick_once();
        chk(port_out[7:4] == 4'h0, "R7", port_out[7:4], 0);
        for (int i = 0; i < 4; i++) begin
          logic b;
          b = port_out[i];
          if (b) hi_cnt[i]++;
          if (m_lvl[i] == 8'd0) chk(b == 1'b0, "R6", b, 0);
          if (m_lvl[i] == 8'd128 && t > 0) chk(b != prev_bit[i], "R4", b, !prev_bit[i]);
          if (m_lvl[i] <= 8'd128 && t > 0 && prev_bit[i]) chk(b == 1'b0, "R10", b, 0);
          prev_bit[i] = b;
        end
        if ((t % 16) == 5) begin
          @(negedge clk);
          chk(port_out == m_out, "R8", port_out, m_out);
        end
      end
      for (int i = 0; i < 4; i++) begin
        chk(hi_cnt[i] == int'(m_lvl[i]), "R3", hi_cnt[i], m_lvl[i]);
        if (m_lvl[i] == 8'd1)   chk(hi_cnt[i] == 1, "R5", hi_cnt[i], 1);
        if (m_lvl[i] == 8'd255) chk(hi_cnt[i] == 255, "R5", hi_cnt[i], 255);
      end
    end

    // Bit placement: only channel 2 active at level 128
    load(8'd0, 8'd0, 8'd128, 8'd0);
    for (int t = 0; t < 4; t++) begin
      tick_once();
      chk((port_out & 8'hFB) == 8'h00, "R7", port_out, m_out);
    end

    // Load on the same cycle as a tick: old levels used for that tick
    load(8'd10, 8'd20, 8'd30, 8'd40);
    @(negedge clk);
    tick = 1'b1;
    lvl_valid = 1'b1;
    lvl_data = {8'd255, 8'd255, 8'd255, 8'd255};
    model_tick();
    m_lvl[0] = 255; m_lvl[1] = 255; m_lvl[2] = 255; m_lvl[3] = 255;
    @(negedge clk);
    tick = 1'b0;
    lvl_valid = 1'b0;
    chk(port_out == m_out, "R9", port_out, m_out);
    tick_once();
    chk(port_out == m_out, "R9", port_out, m_out);

    // Mid-run reset clears integrators and levels
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(port_out == 8'h00, "R1", port_out, 0);
    rst = 1'b0;
    model_clear();
    tick_once();
    chk(port_out == 8'h00, "R1", port_out, 0);
    load(8'd200, 8'd200, 8'd200, 8'd200);
    tick_once();
    chk(port_out == 8'h00, "R1", port_out, 0);
    tick_once();
    chk(port_out == 8'h0F, "R1", port_out, 8'h0F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule